// File: doc/BRIEF.md
# Variable-Size Register Window Renamer

This block translates logical register numbers into physical register numbers for a 128-entry integer register file. The low 32 registers form a fixed region that always maps to itself. The upper 96 registers form a circular pool. Each function sees a window on that pool made of three consecutive areas: inputs first, then locals, then outputs. Every function sizes its own window. An access to a stacked logical number beyond the current window is flagged, and a write to it is suppressed.

Three commands change the window. An allocate command sets the local and output counts and keeps the inputs. A call hides the caller's inputs and locals, and the caller's outputs become the callee's inputs, starting at logical 32. A return brings back the caller's window from a small stack of saved descriptors. Moving hidden registers to and from memory is left to a separate engine. This block only raises a spill request when an allocate would hold more than 96 stacked registers, or a fill request when a return needs caller registers that were spilled. While a request is open the block is busy and waits for an acknowledge.

Top module: `rw_renamer`

## Requirements
- R1: Logical registers 0 to 31 map to the same physical number and are never flagged, whatever the current window.
- R2: A stacked logical register L inside the window maps to physical ((base + L - 32) mod 96) + 32. Read and write results are registered and appear one clock after the address is presented.
- R3: A stacked logical register whose offset L - 32 is at least the window total (inputs + locals + outputs) raises its bad flag, and the write enable output stays low for it.
- R4: After reset the window is empty with base 0, so every stacked register is flagged. No request is raised, busy is low, and the save stack is empty.
- R5: Allocate (cmd_op 01) sets the local and output counts and keeps the input count. If inputs + locals + outputs would exceed 96, cmd_err pulses for one cycle and the window is unchanged.
- R6: Call (cmd_op 10) advances the base by the caller's inputs + locals. The callee's input count becomes the caller's output count, and its locals and outputs are zero. Callee logical 32 therefore reaches the caller's first output.
- R7: Return (cmd_op 11) restores the base and all three counts of the caller exactly as they stood at the call.
- R8: A call while the save stack is full, or a return while it is empty, pulses cmd_err for one cycle and leaves the window unchanged.
- R9: An allocate that would raise the resident stacked count (resident hidden registers plus the new window) above 96 raises spill_req and busy and is not applied. It takes effect in the cycle mem_ack is seen, which clears the request and counts every hidden register as spilled.
- R10: A return whose caller inputs and locals are not all resident raises fill_req and busy and is not applied. It takes effect in the cycle mem_ack is seen.
- R11: The base and the mapping wrap modulo 96 inside the stacked pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_lreg | input | 7 | Logical read register number |
| rd_preg | output | 7 | Physical read register number (registered) |
| rd_bad | output | 1 | Read register lies outside the window (registered) |
| wr_lreg | input | 7 | Logical write register number |
| wr_en | input | 1 | Write request |
| wr_preg | output | 7 | Physical write register number (registered) |
| wr_go | output | 1 | Write enable to the file, low for a flagged register |
| wr_bad | output | 1 | Write register lies outside the window (registered) |
| cmd_op | input | 2 | 00 none, 01 allocate, 10 call, 11 return |
| cmd_loc | input | 8 | Local count for allocate |
| cmd_out | input | 8 | Output count for allocate |
| mem_ack | input | 1 | Acknowledge from the spill/fill engine |
| spill_req | output | 1 | Spill needed before a pending allocate |
| fill_req | output | 1 | Fill needed before a pending return |
| busy | output | 1 | A command waits for mem_ack; new commands are ignored |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench keeps the 32-register fixed region and the 96-register pool, and cuts the save stack to 4 entries. With that depth, a full stack is reached after four calls, so the rejected fifth call and the unwinding of four frames stay short. The full-size pool is kept so that one 94-register window over a rotated base shows both a spill and the modulo-96 wrap. A return into that spilled caller then exercises the fill path.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int CW = 8;
  typedef logic [CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ALLOC = 2'b01,
    OP_CALL  = 2'b10,
    OP_RET   = 2'b11
  } op_e;

  typedef struct packed {
    cnt_t base;
    cnt_t nin;
    cnt_t nloc;
    cnt_t nout;
  } frame_t;
endpackage

// File: rtl/rw_map.sv
module rw_map
  import rw_pkg::*;
#(
  parameter int NSTAT = 32,
  parameter int NSTK  = 96,
  parameter int LW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  cnt_t          base,
  input  cnt_t          total,
  input  logic [LW-1:0] rd_lreg,
  input  logic [LW-1:0] wr_lreg,
  input  logic          wr_en,
  output logic [LW-1:0] rd_preg,
  output logic          rd_bad,
  output logic [LW-1:0] wr_preg,
  output logic          wr_go,
  output logic          wr_bad
);
  // returns {bad, physical}
  function automatic logic [LW:0] xlate(input logic [LW-1:0] l, input cnt_t b, input cnt_t t);
    int off;
    int idx;
    if (int'(l) < NSTAT) return {1'b0, l};
    off = int'(l) - NSTAT;
    idx = int'(b) + off;
    if (idx >= NSTK) idx = idx - NSTK;
    return {(off >= int'(t)), LW'(idx + NSTAT)};
  endfunction

  logic [LW:0] rd_x;
  logic [LW:0] wr_x;

  always_comb begin
    rd_x = xlate(rd_lreg, base, total);
    wr_x = xlate(wr_lreg, base, total);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_preg <= '0;
      rd_bad  <= 1'b0;
      wr_preg <= '0;
      wr_bad  <= 1'b0;
      wr_go   <= 1'b0;
    end else begin
      rd_preg <= rd_x[LW-1:0];
      rd_bad  <= rd_x[LW];
      wr_preg <= wr_x[LW-1:0];
      wr_bad  <= wr_en & wr_x[LW];
      wr_go   <= wr_en & ~wr_x[LW];
    end
  end

  // R3
  wr_suppress_chk: assert property (@(posedge clk) disable iff (rst) wr_bad |-> !wr_go);
  // R1
  static_ident_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_lreg) < NSTAT) |=> (!rd_bad && rd_preg == $past(rd_lreg)));
endmodule

// File: rtl/rw_stack.sv
module rw_stack
  import rw_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push_en,
  input  frame_t push_d,
  input  logic   pop_en,
  output frame_t top_d,
  output logic   empty,
  output logic   full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  frame_t        mem [DEPTH];
  logic [NW-1:0] cnt;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] top_idx;

  assign wr_idx  = IW'(cnt);
  assign top_idx = IW'(cnt - NW'(1));
  assign empty   = (cnt == '0);
  assign full    = (cnt == NW'(DEPTH));
  assign top_d   = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push_en) mem[wr_idx] <= push_d;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push_en && !pop_en) cnt <= cnt + NW'(1);
    else if (pop_en && !push_en) cnt <= cnt - NW'(1);
  end

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst) !(push_en && full));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst) !(pop_en && empty));
endmodule

// File: rtl/rw_ctl.sv
module rw_ctl
  import rw_pkg::*;
#(
  parameter int NSTK = 96
) (
  input  logic   clk,
  input  logic   rst,
  input  op_e    op,
  input  cnt_t   a_loc,
  input  cnt_t   a_out,
  input  logic   mem_ack,
  input  frame_t top_d,
  input  logic   st_empty,
  input  logic   st_full,
  output logic   push_en,
  output frame_t push_d,
  output logic   pop_en,
  output cnt_t   base_o,
  output cnt_t   total_o,
  output logic   busy,
  output logic   spill_req,
  output logic   fill_req,
  output logic   cmd_err
);
  localparam int SW = CW + 2;

  frame_t        cur;
  cnt_t          sv;
  cnt_t          p_loc;
  cnt_t          p_out;
  logic [SW-1:0] want;
  logic [SW-1:0] used_new;
  logic [SW-1:0] bsum;
  cnt_t          nbase;
  cnt_t          need;
  logic          ret_now;

  always_comb begin
    want     = SW'(cur.nin) + SW'(a_loc) + SW'(a_out);
    used_new = want + SW'(sv);
    bsum     = SW'(cur.base) + SW'(cur.nin) + SW'(cur.nloc);
    nbase    = (bsum >= SW'(NSTK)) ? CW'(bsum - SW'(NSTK)) : CW'(bsum);
    need     = top_d.nin + top_d.nloc;
    ret_now  = !busy && op == OP_RET && !st_empty && sv >= need;
    push_en  = !busy && op == OP_CALL && !st_full;
    push_d   = cur;
    pop_en   = ret_now || (fill_req && mem_ack);
  end

  assign busy    = spill_req | fill_req;
  assign base_o  = cur.base;
  assign total_o = cur.nin + cur.nloc + cur.nout;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      sv        <= '0;
      p_loc     <= '0;
      p_out     <= '0;
      spill_req <= 1'b0;
      fill_req  <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (spill_req) begin
        if (mem_ack) begin
          cur.nloc  <= p_loc;
          cur.nout  <= p_out;
          sv        <= '0;
          spill_req <= 1'b0;
        end
      end else if (fill_req) begin
        if (mem_ack) begin
          cur      <= top_d;
          sv       <= '0;
          fill_req <= 1'b0;
        end
      end else begin
        case (op)
          OP_ALLOC: begin
            if (want > SW'(NSTK)) cmd_err <= 1'b1;
            else if (used_new > SW'(NSTK)) begin
              spill_req <= 1'b1;
              p_loc     <= a_loc;
              p_out     <= a_out;
            end else begin
              cur.nloc <= a_loc;
              cur.nout <= a_out;
            end
          end
          OP_CALL: begin
            if (st_full) cmd_err <= 1'b1;
            else begin
              cur.base <= nbase;
              cur.nin  <= cur.nout;
              cur.nloc <= '0;
              cur.nout <= '0;
              sv       <= sv + cur.nin + cur.nloc;
            end
          end
          OP_RET: begin
            if (st_empty) cmd_err <= 1'b1;
            else if (ret_now) begin
              cur <= top_d;
              sv  <= sv - need;
            end else fill_req <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (rst) !(spill_req && fill_req));
  // R9
  spill_hold_chk: assert property (@(posedge clk) disable iff (rst) (spill_req && !mem_ack) |=> spill_req);
  // R10
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst) (fill_req && !mem_ack) |=> fill_req);
  // R5
  frame_fit_chk: assert property (@(posedge clk) disable iff (rst)
    (SW'(cur.nin) + SW'(cur.nloc) + SW'(cur.nout)) <= SW'(NSTK));
  // R9
  resident_fit_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (SW'(sv) + SW'(total_o)) <= SW'(NSTK));
  // R11
  base_range_chk: assert property (@(posedge clk) disable iff (rst) SW'(cur.base) < SW'(NSTK));
endmodule

// File: rtl/rw_renamer.sv
module rw_renamer
  import rw_pkg::*;
#(
  parameter  int NSTAT = 32,
  parameter  int NSTK  = 96,
  parameter  int DEPTH = 16,
  localparam int LW    = $clog2(NSTAT + NSTK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_lreg,
  output logic [LW-1:0] rd_preg,
  output logic          rd_bad,
  input  logic [LW-1:0] wr_lreg,
  input  logic          wr_en,
  output logic [LW-1:0] wr_preg,
  output logic          wr_go,
  output logic          wr_bad,
  input  logic [1:0]    cmd_op,
  input  logic [CW-1:0] cmd_loc,
  input  logic [CW-1:0] cmd_out,
  input  logic          mem_ack,
  output logic          spill_req,
  output logic          fill_req,
  output logic          busy,
  output logic          cmd_err
);
  frame_t top_d;
  frame_t push_d;
  logic   push_en;
  logic   pop_en;
  logic   st_empty;
  logic   st_full;
  cnt_t   base;
  cnt_t   total;

  rw_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push_en(push_en), .push_d(push_d), .pop_en(pop_en),
    .top_d(top_d), .empty(st_empty), .full(st_full)
  );

  rw_ctl #(.NSTK(NSTK)) u_ctl (
    .clk(clk), .rst(rst), .op(op_e'(cmd_op)), .a_loc(cmd_loc), .a_out(cmd_out),
    .mem_ack(mem_ack), .top_d(top_d), .st_empty(st_empty), .st_full(st_full),
    .push_en(push_en), .push_d(push_d), .pop_en(pop_en), .base_o(base), .total_o(total),
    .busy(busy), .spill_req(spill_req), .fill_req(fill_req), .cmd_err(cmd_err)
  );

  rw_map #(.NSTAT(NSTAT), .NSTK(NSTK), .LW(LW)) u_map (
    .clk(clk), .rst(rst), .base(base), .total(total), .rd_lreg(rd_lreg),
    .wr_lreg(wr_lreg), .wr_en(wr_en), .rd_preg(rd_preg), .rd_bad(rd_bad),
    .wr_preg(wr_preg), .wr_go(wr_go), .wr_bad(wr_bad)
  );
endmodule

// File: tb/rw_renamer_tb.sv
`timescale 1ns/1ps
module rw_renamer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] rd_lreg = '0;
  logic [6:0] wr_lreg = '0;
  logic       wr_en = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_loc = '0;
  logic [7:0] cmd_out = '0;
  logic       mem_ack = 1'b0;
  logic [6:0] rd_preg, wr_preg;
  logic       rd_bad, wr_go, wr_bad, spill_req, fill_req, busy, cmd_err;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rw_renamer #(.NSTAT(32), .NSTK(96), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .rd_lreg(rd_lreg), .rd_preg(rd_preg), .rd_bad(rd_bad),
    .wr_lreg(wr_lreg), .wr_en(wr_en), .wr_preg(wr_preg), .wr_go(wr_go), .wr_bad(wr_bad),
    .cmd_op(cmd_op), .cmd_loc(cmd_loc), .cmd_out(cmd_out), .mem_ack(mem_ack),
    .spill_req(spill_req), .fill_req(fill_req), .busy(busy), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int loc, input int outs);
    @(negedge clk);
    cmd_op = op; cmd_loc = 8'(loc); cmd_out = 8'(outs);
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic ack();
    @(negedge clk); mem_ack = 1'b1;
    @(negedge clk); mem_ack = 1'b0;
  endtask

  task automatic rd(input string req, input int l, input int exp_p, input bit exp_bad);
    @(negedge clk); rd_lreg = 7'(l);
    @(negedge clk);
    chk(req, int'(rd_bad), int'(exp_bad));
    if (!exp_bad) chk(req, int'(rd_preg), exp_p);
  endtask

  task automatic wr(input string req, input int l, input int exp_p, input bit exp_bad);
    @(negedge clk); wr_lreg = 7'(l); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(req, int'(wr_bad), int'(exp_bad));
    chk(req, int'(wr_go), int'(!exp_bad));
    if (!exp_bad) chk(req, int'(wr_preg), exp_p);
  endtask

  task automatic t_reset();
    chk("R4 spill_req", int'(spill_req), 0);
    chk("R4 fill_req", int'(fill_req), 0);
    chk("R4 busy", int'(busy), 0);
    rd("R4 stacked flagged", 32, 0, 1'b1);
    rd("R1 static map", 5, 5, 1'b0);
    cmd(2'b11, 0, 0);
    chk("R4 empty stack", int'(cmd_err), 1);
  endtask

  task automatic t_alloc_map();
    cmd(2'b01, 3, 4);
    chk("R5 alloc ok", int'(cmd_err), 0);
    rd("R2 first", 32, 32, 1'b0);
    rd("R2 last", 38, 38, 1'b0);
    rd("R3 beyond", 39, 0, 1'b1);
    wr("R3 write suppressed", 39, 0, 1'b1);
    wr("R2 write", 34, 34, 1'b0);
    wr("R1 static write", 3, 3, 1'b0);
    rd("R1 top static", 31, 31, 1'b0);
  endtask

  task automatic t_alloc_reject();
    cmd(2'b01, 90, 10);
    chk("R5 oversize err", int'(cmd_err), 1);
    rd("R5 unchanged in", 38, 38, 1'b0);
    rd("R5 unchanged out", 39, 0, 1'b1);
  endtask

  task automatic t_call_ret();
    cmd(2'b10, 0, 0);
    rd("R6 callee in0", 32, 35, 1'b0);
    rd("R6 callee in3", 35, 38, 1'b0);
    rd("R6 callee size", 36, 0, 1'b1);
    cmd(2'b01, 2, 2);
    rd("R6 callee alloc", 39, 42, 1'b0);
    rd("R6 callee bound", 40, 0, 1'b1);
    cmd(2'b11, 0, 0);
    chk("R7 no fill", int'(fill_req), 0);
    rd("R7 caller restored", 38, 38, 1'b0);
    rd("R7 caller bound", 39, 0, 1'b1);
    cmd(2'b11, 0, 0);
    chk("R8 ret empty err", int'(cmd_err), 1);
    rd("R8 ret empty unchanged", 38, 38, 1'b0);
  endtask

  task automatic t_stack_full();
    for (int i = 0; i < 4; i++) begin
      cmd(2'b10, 0, 0);
      chk("R8 call accepted", int'(cmd_err), 0);
    end
    cmd(2'b10, 0, 0);
    chk("R8 call full err", int'(cmd_err), 1);
    rd("R8 call full unchanged", 32, 0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      cmd(2'b11, 0, 0);
      chk("R7 unwind no fill", int'(fill_req), 0);
    end
    rd("R7 unwound", 38, 38, 1'b0);
    rd("R7 unwound bound", 39, 0, 1'b1);
  endtask

  task automatic t_spill();
    cmd(2'b10, 0, 0);
    cmd(2'b01, 80, 10);
    chk("R9 spill_req", int'(spill_req), 1);
    chk("R9 busy", int'(busy), 1);
    rd("R9 not applied", 36, 0, 1'b1);
    ack();
    chk("R9 spill cleared", int'(spill_req), 0);
    chk("R9 busy cleared", int'(busy), 0);
    rd("R9 applied", 36, 39, 1'b0);
    rd("R11 wrap", 125, 32, 1'b0);
    rd("R3 top bound", 126, 0, 1'b1);
  endtask

  task automatic t_fill();
    cmd(2'b11, 0, 0);
    chk("R10 fill_req", int'(fill_req), 1);
    chk("R10 busy", int'(busy), 1);
    rd("R10 not applied", 38, 41, 1'b0);
    ack();
    chk("R10 fill cleared", int'(fill_req), 0);
    rd("R10 applied", 38, 38, 1'b0);
    rd("R10 applied bound", 39, 0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alloc_map();
    t_alloc_reject();
    t_call_ret();
    t_stack_full();
    t_spill();
    t_fill();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule